// File: doc/BRIEF.md
# Synchronized Trigger Routing Crossbar

This block connects a set of trigger input lines to a set of trigger destinations. Every destination has its own route register. The register picks a source, says whether the route is asynchronous or re-timed, and gives the re-timing edge, an invert flag and a connected flag. The destinations are split into a front zone and a rear zone, which parameter `DST_ZONE` fixes. Each zone has its own synchronization clock. A route re-times onto its own zone's clock and may use that zone's clocks as sources.

All logic runs on one fast system clock. Each zone's synchronization clock arrives as a level, and the block samples it and turns its edges into one-cycle strobes. From those strobes it builds two divided clocks per zone, each with its own programmable divisor. A synchronous route loads its output register only on the strobe that matches the route's clock and edge. An asynchronous route passes its source straight through.

Configuration comes in on a single write port: a write enable, an address and a data word.

Top module: `trig_xbar`

## Requirements
- R1: Reset leaves every destination unconnected, with `trigOut` and `trigOe` low. Both divisors of both zones reset to 2.
- R2: Bit 7 of a route word is the connected flag. A destination whose flag is 0 drives `trigOut` low and `trigOe` low, and a connected destination drives `trigOe` high.
- R3: The source select sits in bits 2:0. Codes 0 to 3 pick `trigIn[code]`, code 4 picks constant low, code 5 picks the zone's full-speed clock, code 6 picks divided clock 1 and code 7 picks divided clock 2.
- R4: Bits 4:3 hold the mode. Mode 0 (asynchronous) drives the source to `trigOut` without a register, and the invert flag (bit 6) has no effect in this mode.
- R5: Mode 1 re-times the route on the zone's full-speed clock. Bit 5 chooses the edge (0 rising, 1 falling). The output loads source XOR invert within four system cycles of that edge and holds across every other cycle.
- R6: Modes 2 and 3 re-time the route on the chosen edge of divided clock 1 or divided clock 2 of the zone.
- R7: The divisor for zone z and divider k (0 for divided clock 1, 1 for divided clock 2) sits at address 4+2z+k. A value N of 2 or more toggles the divided clock on every Nth rising edge of the full-speed clock. A write restarts the divided clock low. A value of 0 or 1 makes the divided clock follow the full-speed clock.
- R8: A synchronous route with the ground source and invert set drives a constant high.
- R9: `DST_ZONE[d]` = 1 puts destination d in the rear zone, which uses `syncClk[1]`. Otherwise destination d uses `syncClk[0]`. The other zone's clock has no effect on d.
- R10: A write to route address d (0 to 3) is in effect from the following cycle, and it clears the synchronous output register of that route.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncClk | input | 2 | Zone synchronization clock levels (0 front, 1 rear) |
| trigIn | input | NUM_SRC | Trigger input lines |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | ADDR_W | Configuration address (routes, then divisors) |
| cfgData | input | CFG_W | Configuration write data |
| trigOut | output | NUM_DST | Routed trigger per destination |
| trigOe | output | NUM_DST | Output enable per destination |

## Verification
A route rewrite and a load strobe on the same route can land on the same clock edge. In that case the clear must win. The bench provokes this by rewriting a route that has already latched a high value. It then checks that the output is low in the next cycle. A checker property makes the same demand whenever a synchronous route is written.

A divisor write can also coincide with a full-speed edge being counted. The bench rewrites the divisor and then counts pulses from zero, so a restart that lost to the edge shows up as a toggle one pulse early.

// File: rtl/trig_xbar_pkg.sv
package trig_xbar_pkg;

  typedef enum logic [1:0] {
    SYNC_NONE = 2'd0,
    SYNC_FULL = 2'd1,
    SYNC_DIV1 = 2'd2,
    SYNC_DIV2 = 2'd3
  } sync_mode_e;

  // Per-zone clock levels and edge strobes handed from control to datapath
  typedef struct packed {
    logic       fullLvl;
    logic       fullRise;
    logic       fullFall;
    logic [1:0] divLvl;
    logic [1:0] divRise;
    logic [1:0] divFall;
  } zone_tick_t;

endpackage

// File: rtl/trig_xbar_clkdiv.sv
module trig_xbar_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fullLvl,
  input  logic             fullRise,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             divLvl
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   cntNext;
  logic             tog;

  assign cntNext = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      cnt <= '0;
      tog <= 1'b0;
    end else if (fullRise) begin
      if (cntNext >= {1'b0, divisor}) begin
        cnt <= '0;
        tog <= ~tog;
      end else begin
        cnt <= cntNext[DIV_W-1:0];
      end
    end
  end

  // Divisor 0 or 1 passes the full-speed clock through
  assign divLvl = (divisor <= DIV_W'(1)) ? fullLvl : tog;

endmodule

// File: rtl/trig_xbar_ctrl.sv
module trig_xbar_ctrl
  import trig_xbar_pkg::*;
#(
  parameter int NUM_DST = 4,
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 2,
  parameter int SEL_W   = 3,
  parameter int ADDR_W  = 3,
  parameter int CFG_W   = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [1:0]                      syncClk,
  input  logic                            cfgWe,
  input  logic [ADDR_W-1:0]               cfgAddr,
  input  logic [CFG_W-1:0]                cfgData,
  output zone_tick_t [1:0]                tick,
  output logic [NUM_DST-1:0][SEL_W-1:0]   routeSel,
  output logic [NUM_DST-1:0][1:0]         routeMode,
  output logic [NUM_DST-1:0]              routeEdge,
  output logic [NUM_DST-1:0]              routeInv,
  output logic [NUM_DST-1:0]              routeConn,
  output logic [NUM_DST-1:0]              routeClr
);

  localparam int MODE_LSB = SEL_W;
  localparam int EDGE_BIT = SEL_W + 2;
  localparam int INV_BIT  = SEL_W + 3;
  localparam int CONN_BIT = SEL_W + 4;

  logic [1:0]                  syncS1, syncS2;
  logic [1:0][1:0]             divHit;
  logic [1:0][1:0][DIV_W-1:0]  divisor;
  logic [1:0][1:0]             divLvl, divLvlD;

  // Address decode: routes first, then two divisors per zone
  always_comb begin
    routeClr = '0;
    divHit   = '0;
    if (cfgWe) begin
      for (int d = 0; d < NUM_DST; d++)
        if (cfgAddr == ADDR_W'(d)) routeClr[d] = 1'b1;
      for (int z = 0; z < 2; z++)
        for (int k = 0; k < 2; k++)
          if (cfgAddr == ADDR_W'(NUM_DST + 2*z + k)) divHit[z][k] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      routeSel  <= '0;
      routeMode <= '0;
      routeEdge <= '0;
      routeInv  <= '0;
      routeConn <= '0;
    end else begin
      for (int d = 0; d < NUM_DST; d++) begin
        if (routeClr[d]) begin
          routeSel[d]  <= cfgData[SEL_W-1:0];
          routeMode[d] <= cfgData[MODE_LSB+1:MODE_LSB];
          routeEdge[d] <= cfgData[EDGE_BIT];
          routeInv[d]  <= cfgData[INV_BIT];
          routeConn[d] <= cfgData[CONN_BIT];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncS1  <= '0;
      syncS2  <= '0;
      divLvlD <= '0;
      for (int z = 0; z < 2; z++)
        for (int k = 0; k < 2; k++)
          divisor[z][k] <= DIV_W'(DIV_RST);
    end else begin
      syncS1  <= syncClk;
      syncS2  <= syncS1;
      divLvlD <= divLvl;
      for (int z = 0; z < 2; z++)
        for (int k = 0; k < 2; k++)
          if (divHit[z][k]) divisor[z][k] <= cfgData[DIV_W-1:0];
    end
  end

  for (genvar z = 0; z < 2; z++) begin : g_zone
    for (genvar k = 0; k < 2; k++) begin : g_div
      trig_xbar_clkdiv #(.DIV_W(DIV_W)) i_div (
        .clk      (clk),
        .rstN     (rstN),
        .fullLvl  (syncS1[z]),
        .fullRise (syncS1[z] & ~syncS2[z]),
        .restart  (divHit[z][k]),
        .divisor  (divisor[z][k]),
        .divLvl   (divLvl[z][k])
      );
    end
    assign tick[z].fullLvl  = syncS1[z];
    assign tick[z].fullRise = syncS1[z] & ~syncS2[z];
    assign tick[z].fullFall = ~syncS1[z] & syncS2[z];
    assign tick[z].divLvl   = divLvl[z];
    assign tick[z].divRise  = divLvl[z] & ~divLvlD[z];
    assign tick[z].divFall  = ~divLvl[z] & divLvlD[z];
  end

endmodule

// File: rtl/trig_xbar_path.sv
module trig_xbar_path
  import trig_xbar_pkg::*;
#(
  parameter int                   NUM_SRC  = 4,
  parameter int                   NUM_DST  = 4,
  parameter int                   SEL_W    = 3,
  parameter logic [NUM_DST-1:0]   DST_ZONE = '0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SRC-1:0]            trigIn,
  input  zone_tick_t [1:0]              tick,
  input  logic [NUM_DST-1:0][SEL_W-1:0] routeSel,
  input  logic [NUM_DST-1:0][1:0]       routeMode,
  input  logic [NUM_DST-1:0]            routeEdge,
  input  logic [NUM_DST-1:0]            routeInv,
  input  logic [NUM_DST-1:0]            routeConn,
  input  logic [NUM_DST-1:0]            routeClr,
  output logic [NUM_DST-1:0]            trigOut,
  output logic [NUM_DST-1:0]            trigOe
);

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    localparam bit ZONE = DST_ZONE[d];
    zone_tick_t zt;
    logic       srcVal;
    logic       load;
    logic       syncQ;

    assign zt = tick[ZONE];

    always_comb begin
      srcVal = 1'b0;
      for (int s = 0; s < NUM_SRC; s++)
        if (routeSel[d] == SEL_W'(s)) srcVal = trigIn[s];
      if      (routeSel[d] == SEL_W'(NUM_SRC + 1)) srcVal = zt.fullLvl;
      else if (routeSel[d] == SEL_W'(NUM_SRC + 2)) srcVal = zt.divLvl[0];
      else if (routeSel[d] == SEL_W'(NUM_SRC + 3)) srcVal = zt.divLvl[1];
    end

    always_comb begin
      case (sync_mode_e'(routeMode[d]))
        SYNC_FULL: load = routeEdge[d] ? zt.fullFall   : zt.fullRise;
        SYNC_DIV1: load = routeEdge[d] ? zt.divFall[0] : zt.divRise[0];
        SYNC_DIV2: load = routeEdge[d] ? zt.divFall[1] : zt.divRise[1];
        default:   load = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN || routeClr[d]) syncQ <= 1'b0;
      else if (load)            syncQ <= srcVal ^ routeInv[d];
    end

    assign trigOut[d] = routeConn[d] &
                        ((routeMode[d] == SYNC_NONE) ? srcVal : syncQ);
    assign trigOe[d]  = routeConn[d];
  end

endmodule

// File: rtl/trig_xbar.sv
module trig_xbar
  import trig_xbar_pkg::*;
#(
  parameter int                 NUM_SRC  = 4,
  parameter int                 NUM_DST  = 4,
  parameter int                 DIV_W    = 8,
  parameter int                 DIV_RST  = 2,
  parameter logic [NUM_DST-1:0] DST_ZONE = NUM_DST'(4'b1100),
  localparam int SEL_W  = $clog2(NUM_SRC + 4),
  localparam int ADDR_W = $clog2(NUM_DST + 4),
  localparam int CFG_W  = (SEL_W + 5 > DIV_W) ? SEL_W + 5 : DIV_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         syncClk,
  input  logic [NUM_SRC-1:0] trigIn,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [CFG_W-1:0]   cfgData,
  output logic [NUM_DST-1:0] trigOut,
  output logic [NUM_DST-1:0] trigOe
);

  zone_tick_t [1:0]              tick;
  logic [NUM_DST-1:0][SEL_W-1:0] routeSel;
  logic [NUM_DST-1:0][1:0]       routeMode;
  logic [NUM_DST-1:0]            routeEdge, routeInv, routeConn, routeClr;

  trig_xbar_ctrl #(
    .NUM_DST(NUM_DST), .DIV_W(DIV_W), .DIV_RST(DIV_RST),
    .SEL_W(SEL_W), .ADDR_W(ADDR_W), .CFG_W(CFG_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .syncClk(syncClk),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .tick(tick), .routeSel(routeSel), .routeMode(routeMode),
    .routeEdge(routeEdge), .routeInv(routeInv), .routeConn(routeConn),
    .routeClr(routeClr)
  );

  trig_xbar_path #(
    .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .SEL_W(SEL_W), .DST_ZONE(DST_ZONE)
  ) i_path (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .tick(tick),
    .routeSel(routeSel), .routeMode(routeMode), .routeEdge(routeEdge),
    .routeInv(routeInv), .routeConn(routeConn), .routeClr(routeClr),
    .trigOut(trigOut), .trigOe(trigOe)
  );

endmodule

// File: rtl/trig_xbar_chk.sv
module trig_xbar_chk #(
  parameter int NUM_DST = 4,
  parameter int SEL_W   = 3,
  parameter int ADDR_W  = 3,
  parameter int CFG_W   = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgWe,
  input logic [ADDR_W-1:0]  cfgAddr,
  input logic [CFG_W-1:0]   cfgData,
  input logic [NUM_DST-1:0] trigOut,
  input logic [NUM_DST-1:0] trigOe
);

  localparam int MODE_LSB = SEL_W;
  localparam int CONN_BIT = SEL_W + 4;

  // R2
  unconn_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigOut & ~trigOe) == '0);

  // R1
  rst_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (trigOe == '0 && trigOut == '0));

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    // R2
    disc_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWe && cfgAddr == ADDR_W'(d) && !cfgData[CONN_BIT]) |=> !trigOe[d]);

    // R10
    conn_next_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWe && cfgAddr == ADDR_W'(d) && cfgData[CONN_BIT]) |=> trigOe[d]);

    // R10
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWe && cfgAddr == ADDR_W'(d) && cfgData[CONN_BIT] &&
       cfgData[MODE_LSB+1:MODE_LSB] != 2'd0) |=> !trigOut[d]);
  end

endmodule

bind trig_xbar trig_xbar_chk #(
  .NUM_DST(NUM_DST), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .CFG_W(CFG_W)
) i_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
  .cfgData(cfgData), .trigOut(trigOut), .trigOe(trigOe)
);

// File: tb/test_trig_xbar.sv
module test_trig_xbar;

  localparam int NS = 4;
  localparam int ND = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    syncClk = '0;
  logic [NS-1:0] trigIn = '0;
  logic          cfgWe = 1'b0;
  logic [2:0]    cfgAddr = '0;
  logic [7:0]    cfgData = '0;
  logic [ND-1:0] trigOut, trigOe;

  int nRun = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  trig_xbar i_trig_xbar (
    .clk(clk), .rstN(rstN), .syncClk(syncClk), .trigIn(trigIn),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .trigOut(trigOut), .trigOe(trigOe)
  );

  task automatic chk(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrCfg(input int addr, input int data);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 3'(addr); cfgData = 8'(data);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // word: [7] conn, [6] invert, [5] edge, [4:3] mode, [2:0] source
  task automatic setRoute(input int d, input int sel, input int mode,
                          input int edgeSel, input int inv, input int conn);
    wrCfg(d, (conn << 7) | (inv << 6) | (edgeSel << 5) | (mode << 3) | sel);
  endtask

  task automatic zclk(input int z, input logic v);
    @(negedge clk);
    syncClk[z] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(input int z);
    zclk(z, 1'b1);
    zclk(z, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 trigOut after reset", int'(trigOut), 0);
    chk("R1 trigOe after reset", int'(trigOe), 0);
    // dst3 (rear) async on divided clock 1, reset divisor 2
    setRoute(3, 6, 0, 0, 0, 1);
    pulse(1);
    chk("R1 div reset 2, one edge", int'(trigOut[3]), 0);
    pulse(1);
    chk("R1 div reset 2, two edges", int'(trigOut[3]), 1);
    setRoute(3, 0, 0, 0, 0, 0);
  endtask

  task automatic t_async;
    setRoute(0, 1, 0, 0, 1, 1);
    chk("R2 oe when connected", int'(trigOe[0]), 1);
    trigIn[1] = 1'b1; #1;
    chk("R4 async pass, invert ignored (high)", int'(trigOut[0]), 1);
    trigIn[1] = 1'b0; #1;
    chk("R4 async pass, invert ignored (low)", int'(trigOut[0]), 0);
  endtask

  task automatic t_unconn;
    setRoute(1, 1, 0, 0, 0, 0);
    trigIn[1] = 1'b1; #1;
    chk("R2 unconnected out low", int'(trigOut[1]), 0);
    chk("R2 unconnected oe low", int'(trigOe[1]), 0);
    trigIn[1] = 1'b0;
  endtask

  task automatic t_syncRise;
    setRoute(0, 2, 1, 0, 0, 1);
    trigIn[2] = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5 holds without clock edge", int'(trigOut[0]), 0);
    zclk(0, 1'b1);
    chk("R5 loads on rising edge", int'(trigOut[0]), 1);
    trigIn[2] = 1'b0;
    zclk(0, 1'b0);
    chk("R5 ignores falling edge", int'(trigOut[0]), 1);
    pulse(0);
    chk("R5 next rising edge loads low", int'(trigOut[0]), 0);
  endtask

  task automatic t_syncFall;
    setRoute(1, 2, 1, 1, 1, 1);
    trigIn[2] = 1'b0;
    zclk(0, 1'b1);
    chk("R5 falling route ignores rise", int'(trigOut[1]), 0);
    zclk(0, 1'b0);
    chk("R5 falling edge loads inverted", int'(trigOut[1]), 1);
  endtask

  task automatic t_groundClear;
    setRoute(0, 4, 1, 0, 1, 1);
    pulse(0);
    chk("R8 inverted ground is high", int'(trigOut[0]), 1);
    setRoute(1, 4, 0, 0, 1, 1);
    chk("R8 async ground stays low", int'(trigOut[1]), 0);
    // rewrite route 0 while it holds 1: cleared next cycle
    setRoute(0, 4, 1, 0, 1, 1);
    chk("R10 rewrite clears sync register", int'(trigOut[0]), 0);
  endtask

  task automatic t_div;
    wrCfg(4, 3);
    setRoute(0, 6, 0, 0, 0, 1);
    chk("R7 divided clock low after restart", int'(trigOut[0]), 0);
    for (int i = 1; i <= 6; i++) begin
      pulse(0);
      chk($sformatf("R7 div3 after %0d edges", i), int'(trigOut[0]),
          (i >= 3 && i < 6) ? 1 : 0);
    end
  endtask

  task automatic t_follow;
    wrCfg(5, 1);
    setRoute(1, 7, 0, 0, 0, 1);
    zclk(0, 1'b1);
    chk("R7 divisor 1 follows high", int'(trigOut[1]), 1);
    zclk(0, 1'b0);
    chk("R7 divisor 1 follows low", int'(trigOut[1]), 0);
    setRoute(1, 5, 0, 0, 0, 1);
    zclk(0, 1'b1);
    chk("R3 full-speed clock source high", int'(trigOut[1]), 1);
    zclk(0, 1'b0);
    chk("R3 full-speed clock source low", int'(trigOut[1]), 0);
  endtask

  task automatic t_divSync;
    wrCfg(4, 3);
    setRoute(0, 3, 2, 0, 0, 1);
    trigIn[3] = 1'b1;
    pulse(0);
    pulse(0);
    chk("R6 no load before divided edge", int'(trigOut[0]), 0);
    pulse(0);
    chk("R6 loads on divided rising edge", int'(trigOut[0]), 1);
    trigIn[3] = 1'b0;
  endtask

  task automatic t_zone;
    setRoute(2, 0, 1, 0, 0, 1);
    trigIn[0] = 1'b1;
    pulse(0);
    pulse(0);
    chk("R9 rear route ignores front clock", int'(trigOut[2]), 0);
    pulse(1);
    chk("R9 rear route loads on rear clock", int'(trigOut[2]), 1);
    setRoute(2, 5, 0, 0, 0, 1);
    zclk(0, 1'b1);
    chk("R9 rear full-speed source not front", int'(trigOut[2]), 0);
    zclk(1, 1'b1);
    chk("R9 rear full-speed source follows rear", int'(trigOut[2]), 1);
    syncClk = '0;
    trigIn[0] = 1'b0;
  endtask

  initial begin
    #1_000_000;
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_async();
    t_unconn();
    t_syncRise();
    t_syncFall();
    t_groundClear();
    t_div();
    t_follow();
    t_divSync();
    t_zone();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule